// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns the program counter and the privilege mode of a simple processor and decides, at each instruction boundary, what they become next. Execution logic raises a step strobe once per completed instruction and offers the sequential next PC. It also tells the block whether that instruction was a software trap (with a vector operand) or a return-from-interrupt. An interrupt source may present one interrupt number in the same step.

When an event is taken, the current `{mode, pc}` pair is pushed onto a small hardware context stack. The block then enters kernel mode and jumps to the handler address held in a writable vector table. A return pops the pair and restores both fields. Stack overflow, stack underflow and out-of-range vector numbers are refused and recorded in sticky flags. The reset layout of the vector table places the process-switch handler at index 0, the process-creation handler at index 1 and the timer-driven scheduler at index 2.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the PC equals RST_PC, the mode equals RST_KMODE (1 = kernel, 0 = user), all three flags are 0, the stack is empty, and vector entry i holds VEC_BASE + i*VEC_STRIDE.
- R2: The PC and mode change only on a cycle with `step_i` high. A step that carries no event loads `pc_seq_i` into the PC and leaves the mode unchanged.
- R3: A step with `irq_valid_i` high and `irq_num_i` < VEC_N pushes {mode, current PC}, sets kernel mode and loads vector[`irq_num_i`]. A trap or return in the same step has no effect, so the pushed PC is the unadvanced PC of that instruction.
- R4: A step with `trap_i` high (and no valid interrupt) pushes {mode, PC+1}, sets kernel mode and loads vector[`trap_num_i`]. A trap takes precedence over a return in the same step.
- R5: A return step pops the top entry and restores both the mode and the PC from it, in last-in first-out order.
- R6: A cycle with `vec_we_i` high and `vec_waddr_i` < VEC_N writes `vec_wdata_i` into that vector entry. Every later entry sequence uses the new value.
- R7: An interrupt or trap that would push onto a full stack (DEPTH entries) is refused: the PC and mode are unchanged, and `stk_ovf_o` is set and stays set until reset.
- R8: A return with an empty stack is refused: the PC and mode are unchanged, and `stk_udf_o` is set and stays set until reset.
- R9: An interrupt or trap number >= VEC_N sets the sticky `vec_err_o` and is otherwise ignored. A bad interrupt lets the step proceed as if no interrupt were present. A bad trap completes as a no-op that loads `pc_seq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Instruction boundary strobe |
| pc_seq_i | input | PC_W | Sequential next PC offered by execution |
| irq_valid_i | input | 1 | Interrupt present this step |
| irq_num_i | input | NUM_W | Interrupt number |
| trap_i | input | 1 | Current instruction is a software trap |
| trap_num_i | input | NUM_W | Trap vector operand |
| reti_i | input | 1 | Current instruction is a return-from-interrupt |
| vec_we_i | input | 1 | Vector table write enable |
| vec_waddr_i | input | NUM_W | Vector table write index |
| vec_wdata_i | input | PC_W | Vector table write data |
| pc_o | output | PC_W | Program counter |
| kmode_o | output | 1 | 1 = kernel mode, 0 = user mode |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |
| stk_udf_o | output | 1 | Sticky stack underflow flag |
| vec_err_o | output | 1 | Sticky out-of-range vector flag |

## Verification
The bench builds the block with PC_W=12, NUM_W=3, VEC_N=6, DEPTH=4, a user-mode reset and VEC_BASE=0x100 with stride 16. A 3-bit number field with six vectors lets every encodable interrupt and trap number be swept, including the two out-of-range codes. A four-deep stack makes overflow reachable after four nested entries. The user-mode reset makes the saved and restored mode bit observable on every return.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SEQ,
    ACT_IRQ,
    ACT_TRAP,
    ACT_RETI,
    ACT_HOLD
  } act_e;

  localparam int unsigned VEC_PROC_SWITCH = 0;
  localparam int unsigned VEC_PROC_CREATE = 1;
  localparam int unsigned VEC_TIMER_SCHED = 2;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
#(
  parameter int unsigned NUM_W = 4,
  parameter int unsigned VEC_N = 8
) (
  input  logic             step_i,
  input  logic             irq_valid_i,
  input  logic [NUM_W-1:0] irq_num_i,
  input  logic             trap_i,
  input  logic [NUM_W-1:0] trap_num_i,
  input  logic             reti_i,
  input  logic             full_i,
  input  logic             empty_i,
  output act_e             act_o,
  output logic [NUM_W-1:0] idx_o,
  output logic             ovf_set_o,
  output logic             udf_set_o,
  output logic             err_set_o
);

  localparam logic [NUM_W:0] VEC_LIM = (NUM_W+1)'(VEC_N);

  logic irq_ok, trap_ok;

  assign irq_ok  = irq_valid_i && ({1'b0, irq_num_i} < VEC_LIM);
  assign trap_ok = trap_i && ({1'b0, trap_num_i} < VEC_LIM);

  // priority: valid irq > trap > return > sequential
  always_comb begin
    act_o     = ACT_NONE;
    idx_o     = '0;
    ovf_set_o = 1'b0;
    udf_set_o = 1'b0;
    err_set_o = 1'b0;
    if (step_i) begin
      err_set_o = (irq_valid_i && !irq_ok) || (!irq_ok && trap_i && !trap_ok);
      if (irq_ok) begin
        idx_o = irq_num_i;
        if (full_i) begin
          act_o     = ACT_HOLD;
          ovf_set_o = 1'b1;
        end else begin
          act_o = ACT_IRQ;
        end
      end else if (trap_i) begin
        idx_o = trap_num_i;
        if (!trap_ok) begin
          act_o = ACT_SEQ;
        end else if (full_i) begin
          act_o     = ACT_HOLD;
          ovf_set_o = 1'b1;
        end else begin
          act_o = ACT_TRAP;
        end
      end else if (reti_i) begin
        if (empty_i) begin
          act_o     = ACT_HOLD;
          udf_set_o = 1'b1;
        end else begin
          act_o = ACT_RETI;
        end
      end else begin
        act_o = ACT_SEQ;
      end
    end
  end

  initial begin
    assert (VEC_N >= 2 && VEC_N <= (1 << NUM_W));
  end

  always_comb begin
    if (step_i && irq_ok) assert (act_o inside {ACT_IRQ, ACT_HOLD});  // R3
    if (act_o == ACT_TRAP) assert (!irq_ok);                          // R4
  end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned      NUM_W      = 4,
  parameter int unsigned      VEC_N      = 8,
  parameter int unsigned      PC_W       = 16,
  parameter logic [PC_W-1:0]  VEC_BASE   = '0,
  parameter int unsigned      VEC_STRIDE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NUM_W-1:0] waddr_i,
  input  logic [PC_W-1:0]  wdata_i,
  input  logic [NUM_W-1:0] raddr_i,
  output logic [PC_W-1:0]  rdata_o
);

  logic [PC_W-1:0] vec_q [VEC_N];

  for (genvar i = 0; i < VEC_N; i++) begin : g_ent
    localparam logic [PC_W-1:0] RST_VAL = PC_W'(VEC_BASE + i * VEC_STRIDE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 vec_q[i] <= RST_VAL;
      else if (we_i && waddr_i == NUM_W'(i))       vec_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < VEC_N; i++) begin
      if (raddr_i == NUM_W'(i)) rdata_o = vec_q[i];
    end
  end

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     mem_q [DEPTH];

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + 1'b1;
    else if (pop_i)  cnt_q <= cnt_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (push_i && cnt_q == CNT_W'(i))    mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_o = mem_q[i];
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o);     // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o);     // R8
  AST_PUSH_POP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(push_i && pop_i));   // R5
  AST_PUSH_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |=> !empty_o);  // R3

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int unsigned     PC_W       = 16,
  parameter int unsigned     NUM_W      = 4,
  parameter int unsigned     VEC_N      = 8,
  parameter int unsigned     DEPTH      = 8,
  parameter logic [PC_W-1:0] RST_PC     = '0,
  parameter logic            RST_KMODE  = 1'b1,
  parameter logic [PC_W-1:0] VEC_BASE   = PC_W'(256),
  parameter int unsigned     VEC_STRIDE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [PC_W-1:0]  pc_seq_i,
  input  logic             irq_valid_i,
  input  logic [NUM_W-1:0] irq_num_i,
  input  logic             trap_i,
  input  logic [NUM_W-1:0] trap_num_i,
  input  logic             reti_i,
  input  logic             vec_we_i,
  input  logic [NUM_W-1:0] vec_waddr_i,
  input  logic [PC_W-1:0]  vec_wdata_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             kmode_o,
  output logic             stk_ovf_o,
  output logic             stk_udf_o,
  output logic             vec_err_o
);

  localparam int unsigned    CTX_W   = PC_W + 1;
  localparam logic [NUM_W:0] VEC_LIM = (NUM_W+1)'(VEC_N);

  act_e             act;
  logic [NUM_W-1:0] vec_idx;
  logic             ovf_set, udf_set, err_set;
  logic             stk_full, stk_empty, stk_push, stk_pop;
  logic [CTX_W-1:0] ctx_wr, ctx_top;
  logic [PC_W-1:0]  vec_addr, pc_save;
  logic [PC_W-1:0]  pc_q;
  logic             kmode_q, ovf_q, udf_q, err_q;

  irq_seq_arb #(.NUM_W(NUM_W), .VEC_N(VEC_N)) u_arb (
    .step_i      (step_i),
    .irq_valid_i (irq_valid_i),
    .irq_num_i   (irq_num_i),
    .trap_i      (trap_i),
    .trap_num_i  (trap_num_i),
    .reti_i      (reti_i),
    .full_i      (stk_full),
    .empty_i     (stk_empty),
    .act_o       (act),
    .idx_o       (vec_idx),
    .ovf_set_o   (ovf_set),
    .udf_set_o   (udf_set),
    .err_set_o   (err_set)
  );

  irq_vec_table #(
    .NUM_W(NUM_W), .VEC_N(VEC_N), .PC_W(PC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vec_we_i),
    .waddr_i (vec_waddr_i),
    .wdata_i (vec_wdata_i),
    .raddr_i (vec_idx),
    .rdata_o (vec_addr)
  );

  // trap saves the advanced PC, interrupts save the unexecuted one
  assign pc_save  = (act == ACT_TRAP) ? pc_q + 1'b1 : pc_q;
  assign ctx_wr   = {kmode_q, pc_save};
  assign stk_push = (act == ACT_IRQ) || (act == ACT_TRAP);
  assign stk_pop  = (act == ACT_RETI);

  irq_ctx_stack #(.DEPTH(DEPTH), .W(CTX_W)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .wdata_i (ctx_wr),
    .top_o   (ctx_top),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RST_PC;
      kmode_q <= RST_KMODE;
    end else begin
      unique case (act)
        ACT_SEQ:  pc_q <= pc_seq_i;
        ACT_IRQ,
        ACT_TRAP: begin
          pc_q    <= vec_addr;
          kmode_q <= 1'b1;
        end
        ACT_RETI: {kmode_q, pc_q} <= ctx_top;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | ovf_set;
      udf_q <= udf_q | udf_set;
      err_q <= err_q | err_set;
    end
  end

  assign pc_o      = pc_q;
  assign kmode_o   = kmode_q;
  assign stk_ovf_o = ovf_q;
  assign stk_udf_o = udf_q;
  assign vec_err_o = err_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(kmode_o));                                            // R2
  AST_IRQ_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && irq_valid_i && ({1'b0, irq_num_i} < VEC_LIM) && !stk_full |=> kmode_o);          // R3
  AST_TRAP_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !irq_valid_i && trap_i && ({1'b0, trap_num_i} < VEC_LIM) && !stk_full |=> kmode_o); // R4
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && irq_valid_i && ({1'b0, irq_num_i} < VEC_LIM) && stk_full
    |=> $stable(pc_o) && $stable(kmode_o) && stk_ovf_o);                                       // R7
  AST_UDF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !irq_valid_i && !trap_i && reti_i && stk_empty
    |=> $stable(pc_o) && $stable(kmode_o) && stk_udf_o);                                       // R8
  AST_BAD_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && irq_valid_i && !({1'b0, irq_num_i} < VEC_LIM) |=> vec_err_o);                    // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_ovf_o |=> stk_ovf_o); // R7
  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_udf_o |=> stk_udf_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) vec_err_o |=> vec_err_o); // R9

endmodule

// File: tb/sim_irq_seq_top.sv
`timescale 1ns/1ps
module sim_irq_seq_top;

  localparam int PC_W  = 12;
  localparam int NUM_W = 3;
  localparam int VEC_N = 6;
  localparam int DEPTH = 4;
  localparam int BASE  = 'h100;
  localparam int STRD  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             step = 1'b0;
  logic [PC_W-1:0]  pc_seq = '0;
  logic             irq_v = 1'b0;
  logic [NUM_W-1:0] irq_n = '0;
  logic             trap_v = 1'b0;
  logic [NUM_W-1:0] trap_n = '0;
  logic             reti = 1'b0;
  logic             we = 1'b0;
  logic [NUM_W-1:0] waddr = '0;
  logic [PC_W-1:0]  wdata = '0;
  logic [PC_W-1:0]  pc;
  logic             kmode, ovf, udf, verr;

  always #4 clk = ~clk;

  irq_seq_top #(
    .PC_W(PC_W), .NUM_W(NUM_W), .VEC_N(VEC_N), .DEPTH(DEPTH),
    .RST_PC(12'h000), .RST_KMODE(1'b0), .VEC_BASE(12'h100), .VEC_STRIDE(STRD)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .pc_seq_i(pc_seq),
    .irq_valid_i(irq_v), .irq_num_i(irq_n), .trap_i(trap_v), .trap_num_i(trap_n),
    .reti_i(reti), .vec_we_i(we), .vec_waddr_i(waddr), .vec_wdata_i(wdata),
    .pc_o(pc), .kmode_o(kmode), .stk_ovf_o(ovf), .stk_udf_o(udf), .vec_err_o(verr)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference state
  int m_pc = 0;
  int m_k  = 0;
  int m_cnt = 0;
  int m_spc [DEPTH];
  int m_sk  [DEPTH];
  int m_vec [VEC_N];
  int m_ovf = 0, m_udf = 0, m_err = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "pc", int'(pc), m_pc);
    chk(tag, "kmode", int'(kmode), m_k);
    chk(tag, "flags", int'({ovf, udf, verr}), (m_ovf << 2) | (m_udf << 1) | m_err);
  endtask

  task automatic do_step(string tag, int iv, int in, int tv, int tn, int rv, int seq);
    bit ok_i, ok_t;
    ok_i = (iv != 0) && (in < VEC_N);
    ok_t = (tv != 0) && (tn < VEC_N);
    if (iv != 0 && !ok_i) m_err = 1;
    if (ok_i) begin
      if (m_cnt == DEPTH) m_ovf = 1;
      else begin
        m_spc[m_cnt] = m_pc; m_sk[m_cnt] = m_k; m_cnt++;
        m_pc = m_vec[in]; m_k = 1;
      end
    end else if (tv != 0) begin
      if (!ok_t) begin m_err = 1; m_pc = seq & 'hfff; end
      else if (m_cnt == DEPTH) m_ovf = 1;
      else begin
        m_spc[m_cnt] = (m_pc + 1) & 'hfff; m_sk[m_cnt] = m_k; m_cnt++;
        m_pc = m_vec[tn]; m_k = 1;
      end
    end else if (rv != 0) begin
      if (m_cnt == 0) m_udf = 1;
      else begin m_cnt--; m_pc = m_spc[m_cnt]; m_k = m_sk[m_cnt]; end
    end else begin
      m_pc = seq & 'hfff;
    end
    @(negedge clk);
    step = 1'b1; irq_v = iv[0]; irq_n = NUM_W'(in); trap_v = tv[0]; trap_n = NUM_W'(tn);
    reti = rv[0]; pc_seq = PC_W'(seq);
    @(negedge clk);
    step = 1'b0; irq_v = 1'b0; trap_v = 1'b0; reti = 1'b0;
    chk_all(tag);
  endtask

  task automatic vec_write(int a, int d);
    @(negedge clk);
    we = 1'b1; waddr = NUM_W'(a); wdata = PC_W'(d);
    @(negedge clk);
    we = 1'b0;
    if (a < VEC_N) m_vec[a] = d;
  endtask

  initial begin
    for (int i = 0; i < VEC_N; i++) m_vec[i] = BASE + i * STRD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // no step: state holds
    pc_seq = 12'h555;
    repeat (3) @(negedge clk);
    chk_all("R2");
    do_step("R2", 0, 0, 0, 0, 0, 'h020);
    do_step("R2", 0, 0, 0, 0, 0, 'h021);

    // every valid interrupt number, entry then return (also checks R1 vector reset values)
    for (int n = 0; n < VEC_N; n++) begin
      do_step("R3", 1, n, 0, 0, 0, 'h7ff);
      do_step("R5", 0, 0, 0, 0, 1, 'h7ff);
    end

    // every valid trap number: PC advanced before save
    for (int n = 0; n < VEC_N; n++) begin
      do_step("R2", 0, 0, 0, 0, 0, 'h040 + n);
      do_step("R4", 0, 0, 1, n, 0, 'h7ff);
      do_step("R5", 0, 0, 0, 0, 1, 'h7ff);
    end
    // PC wrap on trap advance
    do_step("R2", 0, 0, 0, 0, 0, 'hfff);
    do_step("R4", 0, 0, 1, 2, 0, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);

    // interrupt beats trap and return in the same step
    do_step("R2", 0, 0, 0, 0, 0, 'h080);
    do_step("R3", 1, 2, 1, 4, 0, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);
    do_step("R3", 1, 1, 0, 0, 1, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);

    // trap beats return
    do_step("R4", 0, 0, 1, 3, 1, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);

    // nested entries to overflow, then unwind to underflow
    do_step("R2", 0, 0, 0, 0, 0, 'h0c0);
    for (int n = 0; n < DEPTH; n++) do_step("R3", 1, n, 0, 0, 0, 'h7ff);
    do_step("R7", 1, 5, 0, 0, 0, 'h7ff);
    do_step("R7", 0, 0, 1, 1, 0, 'h7ff);
    for (int n = 0; n < DEPTH; n++) do_step("R5", 0, 0, 0, 0, 1, 'h7ff);
    do_step("R8", 0, 0, 0, 0, 1, 'h7ff);
    do_step("R8", 0, 0, 0, 0, 0, 'h0d0);

    // vector table update, out-of-range write ignored
    vec_write(2, 'h3a0);
    vec_write(7, 'h111);
    do_step("R6", 1, 2, 0, 0, 0, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);
    do_step("R6", 0, 0, 1, 5, 0, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);

    // out-of-range numbers
    for (int n = VEC_N; n < (1 << NUM_W); n++) begin
      do_step("R9", 1, n, 0, 0, 0, 'h200 + n);
      do_step("R9", 0, 0, 1, n, 0, 'h300 + n);
    end
    do_step("R9", 1, 7, 1, 1, 0, 'h7ff);
    do_step("R5", 0, 0, 0, 0, 1, 'h7ff);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule